// File: doc/BRIEF.md
# Physically Tagged Four-Way Cache Controller

This block sits between a processor load/store port and a word-wide memory bus. It holds 16 KB of data in 256 sets of four ways, each line four 32-bit words long. A request arrives with only its in-page word index, which is enough to select the set and the word. The physical tag comes from the translation unit one cycle later, so the set read and the translation overlap.

Loads that hit return their word on the third clock edge after acceptance. Any miss brings the whole four-word line in before the access completes. Stores follow a split policy. A store that hits changes only the cached copy and marks the line dirty. A store that misses allocates the line, merges the new bytes into it, and sends that one merged word to memory, so the line stays clean. Dirty lines are written back in full before their way is refilled. The way to replace is an invalid one if there is one, otherwise the one a tree pseudo-LRU points at.

Top module: `ptag_cache`

## Requirements
- R1: After reset is released, `ready_o` stays low for at least 256 cycles while every line is invalidated. The first access to any address after that misses.
- R2: A load hit raises `rsp_valid_o` on the third rising edge after the accepting edge, and causes no memory transfer.
- R3: A load miss issues four memory reads, lowest address first, at byte offsets 0x0, 0x4, 0x8 and 0xC of the line. It then returns the memory word at the requested word offset, `req_idx_i[1:0]`.
- R4: A store miss first reads the four words of the line. It then issues exactly one memory write of the merged word, with `mem_be_o` equal to the store's byte enables. The allocated line stays clean: evicting it later causes no write-back.
- R5: A store hit causes no memory transfer. Later loads of that word return the updated value.
- R6: Bit i of `req_be_i` selects byte i (bits 8i+7..8i) of the word. Bytes whose enable is 0 keep their previous value.
- R7: A miss whose victim line is dirty first writes that line back as four full-word writes (`mem_be_o` = 0xF), ascending from the victim's line base. The new line's four reads follow.
- R8: Victim choice uses the lowest-numbered invalid way if any way is invalid. Otherwise it uses a 3-bit tree pseudo-LRU, updated on every hit and fill to point away from the way just used. Once ways 0 to 3 of a set have been filled in that order, the next miss there replaces way 0.
- R9: The set and word come from `req_idx_i` = {set[7:0], word[1:0]}, sampled on the accepting edge. The tag comes from `tag_i`, sampled on the following edge. Byte address = {tag, set, word, 2'b00}.
- R10: `rsp_valid_o` is high for exactly one cycle per request. `ready_o` is low from acceptance through the response cycle and returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_idx_i | input | 10 | In-page word index {set, word} |
| req_be_i | input | 4 | Store byte enables |
| req_wdata_i | input | 32 | Store data |
| tag_i | input | 20 | Physical tag, valid the cycle after acceptance |
| ready_o | output | 1 | Controller idle, request accepted when valid |
| rsp_valid_o | output | 1 | Access complete |
| rsp_rdata_o | output | 32 | Load data |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_be_o | output | 4 | Memory write byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Transfer completes this cycle |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The main function is tried with:
- repeated loads to one line, which separate hits from fills by the memory traffic they cause;
- a second tag in an already-filled set, which shows that the late tag, not the index, decides a hit;
- stores to resident and absent lines, which separate the two write policies by whether a single merged write reaches memory;
- five distinct tags streamed into one set, with and without a prior store hit, which exposes the replacement order and whether a write-back comes before the refill.

Partial byte-enable patterns show whether each byte lane is merged independently. The tag bus is driven with the inverted tag during the request cycle, so any design that samples it too early misses where it should hit.

// File: rtl/ptag_cache_pkg.sv
package ptag_cache_pkg;
  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_TAG,
    ST_CMP,
    ST_RESP,
    ST_DONE,
    ST_WB,
    ST_FILL,
    ST_MERGE,
    ST_MWR
  } state_e;
endpackage

// File: rtl/ptag_cache_plru.sv
module ptag_cache_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] touch_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [WAYS-2:0]  plru_o
);
  // tree nodes stored heap-style, node n at bit n-1; bit 0 -> go low half
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) node = node * 2 + int'(plru_i[node-1]);
    victim_o = WAY_W'(node - WAYS);
    for (int w = WAYS - 1; w >= 0; w--) if (!valid_i[w]) victim_o = WAY_W'(w);
  end

  always_comb begin
    int node;
    node   = 1;
    plru_o = plru_i;
    for (int l = 0; l < WAY_W; l++) begin
      plru_o[node-1] = !touch_i[WAY_W-1-l];
      node = node * 2 + int'(touch_i[WAY_W-1-l]);
    end
  end
endmodule

// File: rtl/ptag_cache_store.sv
module ptag_cache_store #(
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WOFF_W = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic [SET_W-1:0]            set_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0]             rd_valid_o,
  output logic [WAYS-1:0]             rd_dirty_o,
  output logic [WAYS-2:0]             rd_plru_o,
  input  logic [WAY_W-1:0]            way_i,
  input  logic [WOFF_W-1:0]           word_i,
  output logic [WORD_W-1:0]           rd_word_o,
  input  logic                        tag_we_i,
  input  logic [TAG_W-1:0]            tag_wdata_i,
  input  logic                        flags_we_i,
  input  logic [WAYS-1:0]             valid_wdata_i,
  input  logic [WAYS-1:0]             dirty_wdata_i,
  input  logic                        plru_we_i,
  input  logic [WAYS-2:0]             plru_wdata_i,
  input  logic                        data_we_i,
  input  logic [WORD_W-1:0]           data_wdata_i
);
  localparam int TA_W = SET_W + WAY_W;
  localparam int DA_W = SET_W + WAY_W + WOFF_W;

  logic [TAG_W-1:0]  tag_q   [SETS*WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-2:0]   plru_q  [SETS];
  logic [WORD_W-1:0] data_q  [SETS*WAYS*WORDS];

  logic [TA_W-1:0] taddr;
  logic [DA_W-1:0] daddr;
  assign taddr = {set_i, way_i};
  assign daddr = {set_i, way_i, word_i};

  for (genvar w = 0; w < WAYS; w++) begin : g_tag_rd
    assign rd_tag_o[w] = tag_q[{set_i, WAY_W'(w)}];
  end

  assign rd_valid_o = valid_q[set_i];
  assign rd_dirty_o = dirty_q[set_i];
  assign rd_plru_o  = plru_q[set_i];
  assign rd_word_o  = data_q[daddr];

  always_ff @(posedge clk_i) begin
    if (tag_we_i) tag_q[taddr] <= tag_wdata_i;
    if (flags_we_i) begin
      valid_q[set_i] <= valid_wdata_i;
      dirty_q[set_i] <= dirty_wdata_i;
    end
    if (plru_we_i) plru_q[set_i] <= plru_wdata_i;
    if (data_we_i) data_q[daddr] <= data_wdata_i;
  end
endmodule

// File: rtl/ptag_cache.sv
module ptag_cache
  import ptag_cache_pkg::*;
#(
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WOFF_W = $clog2(WORDS),
  localparam int IDX_W  = SET_W + WOFF_W,
  localparam int BE_W   = WORD_W / 8,
  localparam int BOFF_W = $clog2(BE_W),
  localparam int ADDR_W = TAG_W + IDX_W + BOFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  state_e              state_q;
  logic [SET_W-1:0]    init_q;
  logic [IDX_W-1:0]    idx_q;
  logic                we_q;
  logic [BE_W-1:0]     be_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [TAG_W-1:0]    ptag_q;
  logic [WAY_W-1:0]    way_q;
  logic [WOFF_W-1:0]   beat_q;
  logic [WORD_W-1:0]   rsp_q;

  logic [SET_W-1:0]           set_w;
  logic [WOFF_W-1:0]          word_w;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]            rd_valid, rd_dirty, hit_vec;
  logic [WAYS-2:0]            rd_plru, plru_upd;
  logic [WORD_W-1:0]          rd_word, merged;
  logic [WAY_W-1:0]           hit_way, victim, sel_way;
  logic [WOFF_W-1:0]          sel_word;
  logic                       hit, xfer, last_beat;

  logic                tag_we, flags_we, plru_we, data_we;
  logic [WAYS-1:0]     valid_wd, dirty_wd;
  logic [WAYS-2:0]     plru_wd;
  logic [WORD_W-1:0]   data_wd;

  assign set_w     = (state_q == ST_INIT) ? init_q : idx_q[IDX_W-1:WOFF_W];
  assign word_w    = idx_q[WOFF_W-1:0];
  assign xfer      = mem_req_o && mem_ready_i;
  assign last_beat = beat_q == WOFF_W'(WORDS - 1);

  for (genvar w = 0; w < WAYS; w++) begin : g_hit
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == ptag_q);
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign sel_way  = (state_q == ST_CMP) ? hit_way : way_q;
  assign sel_word = (state_q == ST_WB || state_q == ST_FILL) ? beat_q : word_w;

  always_comb begin
    for (int b = 0; b < BE_W; b++)
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : rd_word[8*b +: 8];
  end

  ptag_cache_store #(
    .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(TAG_W), .WORD_W(WORD_W)
  ) u_store (
    .clk_i        (clk_i),
    .set_i        (set_w),
    .rd_tag_o     (rd_tag),
    .rd_valid_o   (rd_valid),
    .rd_dirty_o   (rd_dirty),
    .rd_plru_o    (rd_plru),
    .way_i        (sel_way),
    .word_i       (sel_word),
    .rd_word_o    (rd_word),
    .tag_we_i     (tag_we),
    .tag_wdata_i  (ptag_q),
    .flags_we_i   (flags_we),
    .valid_wdata_i(valid_wd),
    .dirty_wdata_i(dirty_wd),
    .plru_we_i    (plru_we),
    .plru_wdata_i (plru_wd),
    .data_we_i    (data_we),
    .data_wdata_i (data_wd)
  );

  ptag_cache_plru #(.WAYS(WAYS)) u_plru (
    .plru_i  (rd_plru),
    .valid_i (rd_valid),
    .touch_i (sel_way),
    .victim_o(victim),
    .plru_o  (plru_upd)
  );

  // array write controls
  always_comb begin
    tag_we   = 1'b0;
    flags_we = 1'b0;
    plru_we  = 1'b0;
    data_we  = 1'b0;
    valid_wd = rd_valid;
    dirty_wd = rd_dirty;
    plru_wd  = plru_upd;
    data_wd  = merged;
    case (state_q)
      ST_INIT: begin
        flags_we = 1'b1;
        plru_we  = 1'b1;
        valid_wd = '0;
        dirty_wd = '0;
        plru_wd  = '0;
      end
      ST_CMP: if (hit) begin
        plru_we = 1'b1;
        if (we_q) begin
          data_we  = 1'b1;
          flags_we = 1'b1;
          dirty_wd = rd_dirty | (WAYS'(1) << hit_way);
        end
      end
      ST_FILL: if (xfer) begin
        data_we = 1'b1;
        data_wd = mem_rdata_i;
        if (last_beat) begin
          tag_we   = 1'b1;
          flags_we = 1'b1;
          plru_we  = 1'b1;
          valid_wd = rd_valid | (WAYS'(1) << way_q);
          dirty_wd = rd_dirty & ~(WAYS'(1) << way_q);
        end
      end
      ST_MERGE: data_we = 1'b1;
      default: ;
    endcase
  end

  // memory side
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = rd_word;
    case (state_q)
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_be_o   = '1;
        mem_addr_o = {rd_tag[way_q], set_w, beat_q, BOFF_W'(0)};
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {ptag_q, set_w, beat_q, BOFF_W'(0)};
      end
      ST_MWR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_be_o   = be_q;
        mem_addr_o = {ptag_q, set_w, word_w, BOFF_W'(0)};
      end
      default: ;
    endcase
  end

  assign ready_o     = state_q == ST_IDLE;
  assign rsp_valid_o = state_q == ST_DONE;
  assign rsp_rdata_o = rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      init_q  <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      ptag_q  <= '0;
      way_q   <= '0;
      beat_q  <= '0;
      rsp_q   <= '0;
    end else begin
      case (state_q)
        ST_INIT: begin
          init_q <= init_q + 1'b1;
          if (init_q == SET_W'(SETS - 1)) state_q <= ST_IDLE;
        end
        ST_IDLE: if (req_valid_i) begin
          idx_q   <= req_idx_i;
          we_q    <= req_we_i;
          be_q    <= req_be_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_TAG;
        end
        ST_TAG: begin
          ptag_q  <= tag_i;  // translation result lands one cycle late
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          beat_q <= '0;
          if (hit) begin
            way_q   <= hit_way;
            state_q <= ST_RESP;
          end else begin
            way_q   <= victim;
            state_q <= (rd_valid[victim] && rd_dirty[victim]) ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (xfer) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_FILL;
        end
        ST_FILL: if (xfer) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= we_q ? ST_MERGE : ST_RESP;
        end
        ST_MERGE: state_q <= ST_MWR;
        ST_MWR:   if (xfer) state_q <= ST_RESP;
        ST_RESP: begin
          rsp_q   <= rd_word;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a tag may live in at most one way of a set
  a_r9_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP) |-> $onehot0(hit_vec));

  // R8: an invalid way is never passed over
  a_r8_invalid_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && !hit && !(&rd_valid)) |-> !rd_valid[victim]);

  // R3: fill beats advance one word at a time
  a_r3_fill_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !mem_we_o && !(&mem_addr_o[BOFF_W+WOFF_W-1:BOFF_W]))
    |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(BE_W)));

  // R5: a store hit reaches the response without touching memory
  a_r5_store_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && hit && we_q) |=> !mem_req_o);

  // R10: single-cycle response, then idle
  a_r10_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && ready_o));
endmodule

// File: tb/ptag_cache_tb_top.sv
`timescale 1ns/1ps
module ptag_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_we_i;
  logic [9:0]  req_idx_i;
  logic [3:0]  req_be_i;
  logic [31:0] req_wdata_i;
  logic [19:0] tag_i;
  logic        ready_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ready_i;
  logic [31:0] mem_rdata_i;

  always #2.5 clk = ~clk;

  ptag_cache dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_idx_i(req_idx_i),
    .req_be_i(req_be_i), .req_wdata_i(req_wdata_i), .tag_i(tag_i),
    .ready_o(ready_o), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [19:0] t, input logic [7:0] s,
                                     input logic [1:0] w);
    return {t, s, w, 2'b00};
  endfunction

  logic [31:0] mem_m [logic [31:0]];
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return pat(a);
  endfunction

  // transfer log of the current operation
  int          log_n;
  logic [31:0] log_addr [32];
  logic [31:0] log_data [32];
  logic [3:0]  log_be   [32];
  logic        log_we   [32];

  initial begin
    mem_ready_i = 1'b0;
    mem_rdata_i = '0;
    log_n       = 0;
    forever begin
      @(negedge clk);
      mem_ready_i = mem_req_o;
      mem_rdata_i = mem_rd(mem_addr_o);
      if (mem_req_o) begin
        if (log_n < 32) begin
          log_addr[log_n] = mem_addr_o;
          log_data[log_n] = mem_we_o ? mem_wdata_o : mem_rd(mem_addr_o);
          log_be[log_n]   = mem_be_o;
          log_we[log_n]   = mem_we_o;
        end
        log_n++;
        if (mem_we_o) mem_m[mem_addr_o] = mrg(mem_rd(mem_addr_o), mem_wdata_o, mem_be_o);
      end
    end
  end

  // one access; tag_i carries the wrong tag during the request cycle (R9)
  task automatic do_op(input bit we, input logic [19:0] t, input logic [7:0] s,
                       input logic [1:0] w, input logic [3:0] be, input logic [31:0] wd,
                       output int lat, output logic [31:0] rd);
    log_n       = 0;
    req_valid_i = 1'b1;
    req_we_i    = we;
    req_idx_i   = {s, w};
    req_be_i    = be;
    req_wdata_i = wd;
    tag_i       = ~t;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    tag_i       = t;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!rsp_valid_o && lat < 1000);
    rd = rsp_rdata_o;
    chk(rsp_valid_o && !ready_o, "R10", "response seen, ready low", {31'b0, ready_o}, 32'h0);
    @(negedge clk);
    chk(!rsp_valid_o && ready_o, "R10", "pulse ends, ready back", {31'b0, rsp_valid_o}, 32'h0);
  endtask

  task automatic chk_reads(input string req, input int first, input logic [19:0] t,
                           input logic [7:0] s);
    for (int k = 0; k < 4; k++) begin
      chk(!log_we[first+k] && log_addr[first+k] == mk(t, s, 2'(k)), req, "fill beat address",
          log_addr[first+k], mk(t, s, 2'(k)));
    end
  endtask

  task automatic t_reset;
    int cnt;
    rst_ni = 1'b0;
    req_valid_i = 1'b0; req_we_i = 1'b0; req_idx_i = '0;
    req_be_i = '0; req_wdata_i = '0; tag_i = '0;
    repeat (3) @(negedge clk);
    chk(!ready_o && !rsp_valid_o && !mem_req_o, "R1", "outputs idle in reset",
        {29'b0, ready_o, rsp_valid_o, mem_req_o}, 32'h0);
    rst_ni = 1'b1;
    cnt = 0;
    while (!ready_o && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= 256, "R1", "invalidation cycles before ready", cnt, 256);
  endtask

  task automatic t_read_paths;
    int lat; logic [31:0] rd;
    do_op(1'b0, 20'h12345, 8'd3, 2'd2, 4'h0, '0, lat, rd);
    chk(log_n == 4, "R1", "first access after reset misses", log_n, 4);
    chk_reads("R3", 0, 20'h12345, 8'd3);
    chk(rd == pat(mk(20'h12345, 8'd3, 2'd2)), "R3", "miss data", rd, pat(mk(20'h12345, 8'd3, 2'd2)));
    do_op(1'b0, 20'h12345, 8'd3, 2'd2, 4'h0, '0, lat, rd);
    chk(lat == 3, "R2", "hit latency", lat, 3);
    chk(log_n == 0, "R2", "hit memory traffic", log_n, 0);
    chk(rd == pat(mk(20'h12345, 8'd3, 2'd2)), "R2", "hit data", rd, pat(mk(20'h12345, 8'd3, 2'd2)));
    do_op(1'b0, 20'h12345, 8'd3, 2'd0, 4'h0, '0, lat, rd);
    chk(log_n == 0 && rd == pat(mk(20'h12345, 8'd3, 2'd0)), "R9", "other word same line, late tag",
        rd, pat(mk(20'h12345, 8'd3, 2'd0)));
    do_op(1'b0, 20'h0ABCD, 8'd3, 2'd2, 4'h0, '0, lat, rd);
    chk(log_n == 4, "R9", "other tag same set misses", log_n, 4);
    chk(rd == pat(mk(20'h0ABCD, 8'd3, 2'd2)), "R9", "other tag data", rd, pat(mk(20'h0ABCD, 8'd3, 2'd2)));
  endtask

  task automatic t_store_hit;
    int lat; logic [31:0] rd, exp;
    do_op(1'b1, 20'h12345, 8'd3, 2'd1, 4'b0101, 32'hAABB_CCDD, lat, rd);
    chk(log_n == 0, "R5", "store hit memory traffic", log_n, 0);
    chk(lat == 3, "R5", "store hit latency", lat, 3);
    exp = mrg(pat(mk(20'h12345, 8'd3, 2'd1)), 32'hAABB_CCDD, 4'b0101);
    do_op(1'b0, 20'h12345, 8'd3, 2'd1, 4'h0, '0, lat, rd);
    chk(rd == exp && log_n == 0, "R6", "byte lanes after store hit", rd, exp);
  endtask

  task automatic t_store_miss;
    int lat; logic [31:0] rd, exp;
    exp = mrg(pat(mk(20'h33333, 8'd9, 2'd1)), 32'h1122_3344, 4'b1100);
    do_op(1'b1, 20'h33333, 8'd9, 2'd1, 4'b1100, 32'h1122_3344, lat, rd);
    chk(log_n == 5, "R4", "store miss transfer count", log_n, 5);
    chk_reads("R4", 0, 20'h33333, 8'd9);
    chk(log_we[4] && log_addr[4] == mk(20'h33333, 8'd9, 2'd1), "R4", "store miss write address",
        log_addr[4], mk(20'h33333, 8'd9, 2'd1));
    chk(log_be[4] == 4'b1100, "R6", "store miss byte enables", {28'b0, log_be[4]}, 32'hC);
    chk(log_data[4] == exp, "R6", "store miss merged word", log_data[4], exp);
    do_op(1'b0, 20'h33333, 8'd9, 2'd1, 4'h0, '0, lat, rd);
    chk(rd == exp && log_n == 0, "R4", "allocated line holds merged word", rd, exp);
    // fill ways 1..3, then the next miss replaces the store-miss line
    for (int k = 1; k <= 3; k++) do_op(1'b0, 20'h33333 + 20'(k), 8'd9, 2'd0, 4'h0, '0, lat, rd);
    do_op(1'b0, 20'h33340, 8'd9, 2'd0, 4'h0, '0, lat, rd);
    chk(log_n == 4, "R4", "clean victim, no write-back", log_n, 4);
    chk_reads("R4", 0, 20'h33340, 8'd9);
  endtask

  task automatic t_evict;
    int lat; logic [31:0] rd, exp;
    logic [19:0] tg [5];
    for (int k = 0; k < 5; k++) tg[k] = 20'hA0000 + 20'(k);
    do_op(1'b0, tg[0], 8'd5, 2'd0, 4'h0, '0, lat, rd);
    do_op(1'b1, tg[0], 8'd5, 2'd0, 4'hF, 32'hDEAD_BEEF, lat, rd);
    chk(log_n == 0, "R5", "store hit marks dirty, no traffic", log_n, 0);
    for (int k = 1; k <= 3; k++) begin
      do_op(1'b0, tg[k], 8'd5, 2'd3, 4'h0, '0, lat, rd);
      chk(log_n == 4, "R8", "invalid ways filled first", log_n, 4);
    end
    do_op(1'b0, tg[4], 8'd5, 2'd2, 4'h0, '0, lat, rd);
    chk(log_n == 8, "R7", "write-back plus fill count", log_n, 8);
    for (int k = 0; k < 4; k++) begin
      exp = (k == 0) ? 32'hDEAD_BEEF : pat(mk(tg[0], 8'd5, 2'(k)));
      chk(log_we[k] && log_be[k] == 4'hF && log_addr[k] == mk(tg[0], 8'd5, 2'(k)), "R7",
          "write-back beat address", log_addr[k], mk(tg[0], 8'd5, 2'(k)));
      chk(log_data[k] == exp, "R7", "write-back beat data", log_data[k], exp);
    end
    chk_reads("R7", 4, tg[4], 8'd5);
    chk(rd == pat(mk(tg[4], 8'd5, 2'd2)), "R7", "data after write-back", rd, pat(mk(tg[4], 8'd5, 2'd2)));
    for (int k = 1; k <= 3; k++) begin
      do_op(1'b0, tg[k], 8'd5, 2'd3, 4'h0, '0, lat, rd);
      chk(log_n == 0, "R8", "non-victim ways still resident", log_n, 0);
    end
    do_op(1'b0, tg[0], 8'd5, 2'd0, 4'h0, '0, lat, rd);
    chk(log_n == 4, "R8", "way 0 was the victim", log_n, 4);
    chk(rd == 32'hDEAD_BEEF, "R7", "written-back word reread", rd, 32'hDEAD_BEEF);
  endtask

  initial begin
    t_reset();
    t_read_paths();
    t_store_hit();
    t_store_miss();
    t_evict();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule